// File: doc/BRIEF.md
# Programmable Interval Interrupt Generator

This block turns a free-running system clock into periodic interrupt requests at an interval chosen by software. The CPU writes one byte to a single output port. The upper field of that byte enables any of three interval sources: 1 ms, 100 ms and 1 s. The lower nibble loads a current-priority status value, which the neighbouring priority-encoding logic compares against incoming requests. Three synchronous dividers, all restarted together by reset, produce a 50% square wave for each interval. The selected waves are ANDed together, and each rising edge of the result is one interval pulse.

A single request flip-flop drives the interrupt line. An interval pulse sets it and an acknowledge clears it. If a pulse arrives while a request is still waiting, the request is withdrawn instead, and the next pulse raises it again. An unserviced source therefore requests on every other interval until the CPU keeps up. When several intervals are enabled, the faster wave is gated by the slower ones rather than replaced by the fastest one. With 1 ms and 1 s both enabled, for example, requests come every millisecond during the second half of each second and stop completely in the first half.

The priority nibble is reloaded on every accepted port write. Its three low bits hold the level in complemented form. The block outputs both the raw nibble and the true level, and the raw nibble resets to all ones.

Top module: `interval_irq_gen`

## Requirements
- R1: After reset, `irqReq` is 0, `prioStatus` is 4'b1111, `prioLevel` is 3'b000 and no interval source is enabled, so no request rises until a port write enables one.
- R2: A cycle with `wrEn` high and `wrAddr` equal to PORT_ADDR loads `wrData[3:0]` into `prioStatus`, visible from the next cycle. Writes to any other address, and cycles with `wrEn` low, change nothing.
- R3: `prioLevel` is always the bitwise complement of `prioStatus[2:0]`. `prioStatus[3]` is passed through unmodified.
- R4: Each bit of `wrData[6:4]`, taken on the same accepted write, enables one interval: bit 4 selects a period of CLK_HZ/1000 cycles, bit 5 a period of CLK_HZ/10 cycles and bit 6 a period of CLK_HZ cycles. `wrData[7]` is ignored. Each wave is low for the first half of its period and high for the second half, counted in clock cycles from the release of reset. With one source enabled and every request acknowledged, `irqReq` rises exactly once per period, one cycle after the wave rises.
- R5: With several sources enabled, pulses come from the rising edges of the AND of the enabled waves. With 1 ms and 1 s enabled, no request rises during the first half of each second, and the second half of each second produces (CLK_HZ/2)/(CLK_HZ/1000) rises.
- R6: An interval pulse that arrives while `irqReq` is high and `irqAck` is low clears `irqReq`. The next pulse sets it again, so with no acknowledge a single source yields one rise every two periods.
- R7: `irqAck` high clears `irqReq` on the next cycle. When `irqAck` and an interval pulse fall in the same cycle, `irqReq` is 1 on the next cycle.
- R8: A write with `wrData[6:4]` equal to 3'b000 stops all interval pulses, and `irqReq` is 0 from the second cycle after the write onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | CPU output-port write strobe |
| wrAddr | input | ADDR_W | CPU output-port address |
| wrData | input | 8 | Written byte: [6:4] interval enables, [3:0] priority nibble |
| irqAck | input | 1 | Interrupt acknowledge, clears the request |
| irqReq | output | 1 | Interrupt request |
| prioStatus | output | 4 | Raw current-priority nibble as written |
| prioLevel | output | 3 | True priority level, complement of the nibble's low three bits |

## Verification
The hardest case to reach is an acknowledge that falls in exactly the cycle of an interval pulse. Both that pulse and the withdrawal of an unserviced request depend on divider phase, which is not visible at the ports. The bench tracks the cycles since reset and the enabled sources. From these it predicts whether the next edge carries a pulse, and it raises the acknowledge in just those cycles. Long stretches with no acknowledge drive the withdraw-and-reassert pattern, and a window aligned to whole seconds counts the rises in each half-second for the gated 1 ms plus 1 s mode.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int NUM_RATES = 3;

  // Strobes handed from control to datapath on an accepted port write.
  typedef struct packed {
    logic                 loadCfg;
    logic [NUM_RATES-1:0] rateBits;
    logic [3:0]           prioBits;
  } cfg_strobe_t;

  // Divider period in clock cycles for each interval source:
  // index 0 -> 1 ms, index 1 -> 100 ms, index 2 -> 1 s.
  function automatic int ratePeriod(input int clkHz, input int idx);
    case (idx)
      0:       return clkHz / 1000;
      1:       return clkHz / 10;
      default: return clkHz;
    endcase
  endfunction

endpackage

// File: rtl/pit_rate_divider.sv
module pit_rate_divider #(
  parameter int PERIOD = 2000
) (
  input  logic clk,
  input  logic rstN,
  output logic wave
);

  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int HALF  = PERIOD / 2;

  logic [CNT_W-1:0] cnt;

  // Free-running count 0..PERIOD-1, restarted only by reset so that all
  // dividers share a common phase origin.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cnt == CNT_W'(PERIOD - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Low for the first half of the period, high for the second half.
  assign wave = (cnt >= CNT_W'(HALF));

endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int CLK_HZ = 2_000_000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfg_strobe_t          cfgStb,
  output logic [NUM_RATES-1:0] rateEn,
  output logic [3:0]           prioStatus,
  output logic                 tickEvt
);

  logic [NUM_RATES-1:0] waves;
  logic                 combined;
  logic                 combPrev;

  // One divider per interval source.
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_div
    pit_rate_divider #(
      .PERIOD(ratePeriod(CLK_HZ, g))
    ) u_div (
      .clk (clk),
      .rstN(rstN),
      .wave(waves[g])
    );
  end

  // Configuration registers: interval enables and priority nibble.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateEn     <= '0;
      prioStatus <= 4'b1111;
    end else if (cfgStb.loadCfg) begin
      rateEn     <= cfgStb.rateBits;
      prioStatus <= cfgStb.prioBits;
    end
  end

  // AND of every enabled wave; nothing enabled means no interval clock.
  always_comb begin
    combined = |rateEn;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (rateEn[i] && !waves[i]) begin
        combined = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      combPrev <= 1'b0;
    end else begin
      combPrev <= combined;
    end
  end

  // An interval pulse is a rising edge of the combined interval clock.
  assign tickEvt = combined & ~combPrev;

endmodule

// File: rtl/pit_control.sv
module pit_control
  import pit_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter [ADDR_W-1:0] PORT_ADDR = 8'h10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [7:0]           wrData,
  input  logic                 irqAck,
  input  logic                 tickEvt,
  input  logic [NUM_RATES-1:0] rateEn,
  output cfg_strobe_t          cfgStb,
  output logic                 irqReq
);

  logic portHit;
  logic unusedTopBit;

  assign portHit      = wrEn && (wrAddr == PORT_ADDR);
  assign unusedTopBit = wrData[7];

  always_comb begin
    cfgStb.loadCfg  = portHit;
    cfgStb.rateBits = wrData[4 +: NUM_RATES];
    cfgStb.prioBits = wrData[3:0];
  end

  // Request flip-flop: set by a pulse, withdrawn by a pulse that finds it
  // still pending, cleared by acknowledge or by deselecting every source.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq <= 1'b0;
    end else if (rateEn == '0) begin
      irqReq <= 1'b0;
    end else if (tickEvt) begin
      irqReq <= irqAck ? 1'b1 : ~irqReq;
    end else if (irqAck) begin
      irqReq <= 1'b0;
    end
  end

endmodule

// File: rtl/interval_irq_gen.sv
module interval_irq_gen
  import pit_pkg::*;
#(
  parameter int          CLK_HZ    = 2_000_000,
  parameter int          ADDR_W    = 8,
  parameter [ADDR_W-1:0] PORT_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              irqAck,
  output logic              irqReq,
  output logic [3:0]        prioStatus,
  output logic [2:0]        prioLevel
);

  cfg_strobe_t          cfgStb;
  logic [NUM_RATES-1:0] rateEn;
  logic                 tickEvt;

  pit_control #(
    .ADDR_W   (ADDR_W),
    .PORT_ADDR(PORT_ADDR)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .irqAck (irqAck),
    .tickEvt(tickEvt),
    .rateEn (rateEn),
    .cfgStb (cfgStb),
    .irqReq (irqReq)
  );

  pit_datapath #(
    .CLK_HZ(CLK_HZ)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgStb    (cfgStb),
    .rateEn    (rateEn),
    .prioStatus(prioStatus),
    .tickEvt   (tickEvt)
  );

  // The low three bits of the nibble carry the level in complemented form.
  assign prioLevel = ~prioStatus[2:0];

endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int          ADDR_W    = 8,
  parameter [ADDR_W-1:0] PORT_ADDR = 8'h10
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic              irqAck,
  input logic              irqReq,
  input logic [3:0]        prioStatus,
  input logic              tickEvt,
  input logic [2:0]        rateEn
);

  // R2: an accepted write lands in the priority nibble on the next cycle.
  a_r2_prio_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == PORT_ADDR) |=> (prioStatus == $past(wrData[3:0])));

  // R2: without an accepted write the nibble holds.
  a_r2_prio_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == PORT_ADDR) |=> $stable(prioStatus));

  // R4: the request only rises after an interval pulse.
  a_r4_rise_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(tickEvt));

  // R6: a pulse finding the request pending without acknowledge withdraws it.
  a_r6_withdraw: assert property (@(posedge clk) disable iff (!rstN)
    (tickEvt && irqReq && !irqAck) |=> !irqReq);

  // R7: acknowledge without a pulse clears the request.
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !tickEvt) |=> !irqReq);

  // R7: a pulse coinciding with acknowledge leaves the request set.
  a_r7_tick_wins: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && tickEvt && rateEn != 3'b000) |=> irqReq);

  // R8: with no source enabled the request is dropped.
  a_r8_none_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rateEn == 3'b000) |=> !irqReq);

endmodule

bind interval_irq_gen pit_checker #(
  .ADDR_W   (ADDR_W),
  .PORT_ADDR(PORT_ADDR)
) u_pit_checker (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .irqAck    (irqAck),
  .irqReq    (irqReq),
  .prioStatus(prioStatus),
  .tickEvt   (tickEvt),
  .rateEn    (rateEn)
);

// File: tb/test_interval_irq_gen.sv
`timescale 1ns/1ps
module test_interval_irq_gen;

  localparam int       T_HZ   = 4000;
  localparam [7:0]     PORT   = 8'h10;
  localparam int       PER_MS = T_HZ / 1000;
  localparam int       PER_HS = T_HZ / 10;
  localparam int       PER_S  = T_HZ;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       irqAck = 1'b0;
  logic       irqReq;
  logic [3:0] prioStatus;
  logic [2:0] prioLevel;

  interval_irq_gen #(
    .CLK_HZ(T_HZ), .ADDR_W(8), .PORT_ADDR(PORT)
  ) i_interval_irq_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irqAck(irqAck), .irqReq(irqReq), .prioStatus(prioStatus),
    .prioLevel(prioLevel)
  );

  always #4 clk = ~clk;  // 125 MHz

  int nVec = 0;
  int nFail = 0;

  // Reference state computed from the requirements.
  logic [2:0] mEn;
  logic [3:0] mPrio;
  logic       mPrev;
  logic       mReq;
  int         t;

  // 0: no ack, 1: ack when request seen, 2: random ack, 3: ack only on predicted pulse
  int         ackMode = 0;
  string      tag = "R1";
  logic       lastReq = 1'b0;
  int         riseLo = 0, riseHi = 0;
  int         hitCnt = 0;
  logic       expectSet = 1'b0;
  int         cycles = 0;

  function automatic logic combOf(input int tt, input logic [2:0] en);
    logic c;
    int per;
    if (en == 3'b000) return 1'b0;
    c = 1'b1;
    for (int i = 0; i < 3; i++) begin
      per = (i == 0) ? PER_MS : (i == 1) ? PER_HS : PER_S;
      if (en[i] && ((tt % per) < per / 2)) c = 1'b0;
    end
    return c;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, t);
    end
  endtask

  // Reference model, stepped on the same edge as the design.
  always @(posedge clk) begin
    logic c, ev;
    if (!rstN) begin
      mEn = '0; mPrio = 4'hF; mPrev = 1'b0; mReq = 1'b0; t = 0;
    end else begin
      c  = combOf(t, mEn);
      ev = c && !mPrev;
      if (mEn == 3'b000)  mReq = 1'b0;
      else if (ev)        mReq = irqAck ? 1'b1 : !mReq;
      else if (irqAck)    mReq = 1'b0;
      mPrev = c;
      if (wrEn && wrAddr == PORT) begin
        mEn = wrData[6:4]; mPrio = wrData[3:0];
      end
      t++;
    end
  end

  // Lockstep comparison, rise counting and acknowledge policy.
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(irqReq == mReq, tag, irqReq, mReq);
      check(prioStatus == mPrio, "R2", prioStatus, mPrio);
      check(prioLevel == ~mPrio[2:0], "R3", prioLevel, 3'(~mPrio[2:0]));
      if (expectSet) begin
        check(irqReq == 1'b1, "R7", irqReq, 1);
        hitCnt++;
      end
      if (irqReq && !lastReq) begin
        if (((t - 1) % PER_S) < PER_S / 2) riseLo++; else riseHi++;
      end
      lastReq = irqReq;
      expectSet = 1'b0;
      case (ackMode)
        1: irqAck = irqReq;
        2: irqAck = ($urandom % 3) == 0;
        3: begin
          irqAck = irqReq && combOf(t, mEn) && !mPrev && !wrEn;
          expectSet = irqAck;
        end
        default: irqAck = 1'b0;
      endcase
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic portWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic clearRises();
    riseLo = 0; riseHi = 0;
  endtask

  task automatic alignSecond();
    @(negedge clk);
    while ((t % PER_S) != 0) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    tick(4);
    rstN = 1'b1;
    tick(2);

    // R1: reset values, nothing enabled
    tag = "R1";
    check(irqReq == 1'b0, "R1", irqReq, 0);
    check(prioStatus == 4'hF, "R1", prioStatus, 15);
    check(prioLevel == 3'b000, "R1", prioLevel, 0);
    clearRises();
    tick(PER_HS);
    check(riseLo + riseHi == 0, "R1", riseLo + riseHi, 0);

    // R2 / R3: accepted and ignored writes
    tag = "R2";
    portWrite(PORT, 8'h05);
    check(prioStatus == 4'h5, "R2", prioStatus, 5);
    check(prioLevel == 3'b010, "R3", prioLevel, 2);
    portWrite(8'h11, 8'h0A);
    check(prioStatus == 4'h5, "R2", prioStatus, 5);
    @(negedge clk); wrEn = 1'b0; wrAddr = PORT; wrData = 8'h0C; @(negedge clk);
    check(prioStatus == 4'h5, "R2", prioStatus, 5);
    portWrite(PORT, 8'h8E);
    check(prioStatus == 4'hE, "R3", prioStatus, 14);
    check(prioLevel == 3'b001, "R3", prioLevel, 1);

    // R4: each source alone with prompt acknowledge
    tag = "R4"; ackMode = 1;
    portWrite(PORT, 8'h17); tick(8); clearRises(); tick(PER_S);
    check(riseLo + riseHi == PER_S / PER_MS, "R4", riseLo + riseHi, PER_S / PER_MS);
    portWrite(PORT, 8'h27); tick(8); clearRises(); tick(PER_S);
    check(riseLo + riseHi == PER_S / PER_HS, "R4", riseLo + riseHi, PER_S / PER_HS);
    portWrite(PORT, 8'h47); tick(8); clearRises(); tick(2 * PER_S);
    check(riseLo + riseHi == 2, "R4", riseLo + riseHi, 2);

    // R5: 1 ms gated by 1 s
    tag = "R5";
    portWrite(PORT, 8'hD3);
    alignSecond(); clearRises(); tick(PER_S);
    check(riseLo == 0, "R5", riseLo, 0);
    check(riseHi == (PER_S / 2) / PER_MS, "R5", riseHi, (PER_S / 2) / PER_MS);
    alignSecond(); clearRises(); tick(PER_S);
    check(riseLo == 0 && riseHi == (PER_S / 2) / PER_MS, "R5", riseHi, (PER_S / 2) / PER_MS);

    // R6: no acknowledge, request toggles every pulse
    tag = "R6"; ackMode = 0;
    portWrite(PORT, 8'h12); tick(8); clearRises(); tick(100 * PER_MS);
    check(riseLo + riseHi == 50, "R6", riseLo + riseHi, 50);

    // R7: acknowledge coinciding with a pulse
    tag = "R7"; ackMode = 3;
    hitCnt = 0;
    tick(60 * PER_MS);
    check(hitCnt > 0, "R7", hitCnt, 1);

    // R8: deselect all sources
    tag = "R8"; ackMode = 0;
    portWrite(PORT, 8'h01);
    @(negedge clk);
    check(irqReq == 1'b0, "R8", irqReq, 0);
    clearRises(); tick(PER_S / 2);
    check(riseLo + riseHi == 0 && irqReq == 1'b0, "R8", riseLo + riseHi, 0);

    // Random writes and acknowledges, lockstep-checked
    tag = "R7"; ackMode = 2;
    for (int k = 0; k < 40; k++) begin
      logic [7:0] a;
      a = (($urandom % 4) == 0) ? 8'($urandom) : PORT;
      portWrite(a, 8'($urandom));
      tick(100 + ($urandom % 700));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  // Watchdog
  initial begin
    wait (cycles > 180000);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 180000);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule